// File: doc/BRIEF.md
# Dynamic Read Termination Controller

This block drives the on-die termination enables for one data byte. There are two enables: one for the data and mask pins and one for the strobe pair. The read path gives the block two timing markers. An early read marker announces a read burst, and a postamble marker flags the last cycle of that burst. From these markers the block tracks a termination window. The window opens one or two cycles ahead of the read preamble and closes a programmable number of cycles after the postamble.

Each pin group has its own dynamic/static selector. In dynamic mode the group's enable follows the window. In static mode the enable is held at its configured level at all times. The configured level of each group is always merged by OR with a byte-wide common termination bit. When the byte enable is low, both outputs are held low. Dynamic mode is expected to be off when the attached memory type uses no termination.

Timing convention: `rd_start_i` pulses for one cycle in cycle t, and the read preamble then falls in cycle t+3. `rd_post_i` pulses in the postamble cycle. The window state is registered, and the outputs are combinational from that state and the configuration inputs.

Top module: `dyn_read_odt`

## Requirements
- R1: While reset is asserted, and after it is released with no reads in flight, both outputs are 0 in dynamic mode. An asynchronous reset discards any window that is open.
- R2: With `lead_sel_i`=0, a read marker in cycle t opens the window in cycle t+1, two cycles before the preamble.
- R3: With `lead_sel_i`=1, a read marker in cycle t opens the window in cycle t+2, one cycle before the preamble.
- R4: A postamble marker in cycle p with `hold_cyc_i`=H keeps the window open through cycle p+H. The window is 0 in cycle p+H+1 if no other read is open.
- R5: A group in dynamic mode (its dyn bit = 1) outputs its configured level OR common while the window is open, and 0 otherwise.
- R6: A group in static mode (its dyn bit = 0) outputs its configured level OR common in every cycle.
- R7: The data group and the strobe group each follow their own dyn bit. One group may be static while the other is dynamic.
- R8: `common_odt_i`=1 turns a group's configured level to 1 even when that group's own configuration bit is 0.
- R9: Two reads whose windows touch give an output that stays 1 with no one-cycle gap.
- R10: When `byte_en_i`=0, both outputs are 0 whatever the mode, the configuration or the window state.
- R11: A postamble marker that arrives while no read is open has no effect. The window stays closed.
- R12: Overlapping reads are counted. The window stays open until the postamble of the last open read, plus the hold time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_en_i | input | 1 | Byte lane enable; 0 forces both outputs low |
| rd_start_i | input | 1 | Early read marker; the preamble follows three cycles later |
| rd_post_i | input | 1 | Read postamble cycle marker |
| lead_sel_i | input | 1 | 0: lead of two cycles; 1: lead of one cycle |
| hold_cyc_i | input | 2 | Cycles the window stays open after the postamble (0 to 3) |
| dq_dyn_i | input | 1 | Data/mask group follows the window when 1 |
| dqs_dyn_i | input | 1 | Strobe group follows the window when 1 |
| dq_odt_cfg_i | input | 1 | Configured termination level for the data/mask group |
| dqs_odt_cfg_i | input | 1 | Configured termination level for the strobe group |
| common_odt_i | input | 1 | Byte-wide termination bit, ORed into both groups |
| dq_odt_o | output | 1 | Termination enable for data and mask pins |
| dqs_odt_o | output | 1 | Termination enable for the strobe pair |

## Verification
Single isolated reads are applied with each lead setting and with hold values of 0 and 2. These patterns separate the one-cycle and two-cycle leads, and they show any off-by-one in the hold countdown. Two reads whose windows just touch, and two reads whose bursts overlap, show whether the window drops for a cycle or closes on the first postamble. A stray postamble with nothing open separates a saturating count from one that wraps. The static, common and enable patterns show whether each group takes its own mode bit and whether the gating happens before or after the OR.

// File: rtl/dyn_read_odt_pkg.sv
package dyn_read_odt_pkg;
  localparam int unsigned N_GRP   = 2;
  localparam int unsigned GRP_DQ  = 0;
  localparam int unsigned GRP_DQS = 1;

  typedef struct packed {
    logic dyn;
    logic lvl;
  } grp_cfg_t;
endpackage

// File: rtl/odt_lead_align.sv
module odt_lead_align (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_start_i,
  input  logic       lead_sel_i,
  output logic [1:0] open_cnt_o
);
  // lead choice is latched with the marker, so a mid-flight change cannot lose a read
  logic late_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) late_q <= 1'b0;
    else         late_q <= rd_start_i & lead_sel_i;
  end

  assign open_cnt_o = {1'b0, rd_start_i & ~lead_sel_i} + {1'b0, late_q};
endmodule

// File: rtl/odt_window_track.sv
module odt_window_track #(
  parameter int unsigned OPEN_W = 3,
  parameter int unsigned HOLD_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        open_cnt_i,
  input  logic              rd_post_i,
  input  logic [HOLD_W-1:0] hold_cyc_i,
  output logic              read_open_o,
  output logic              win_active_o
);
  localparam logic [OPEN_W:0] OPEN_MAX = {1'b0, {OPEN_W{1'b1}}};

  logic [OPEN_W-1:0] open_q;
  logic [HOLD_W-1:0] hold_q;
  logic              post_ok;
  logic [OPEN_W:0]   open_sum;
  logic [OPEN_W:0]   open_nxt;

  assign post_ok  = rd_post_i & (open_q != '0);
  assign open_sum = {1'b0, open_q} + {{(OPEN_W-1){1'b0}}, open_cnt_i};

  always_comb begin
    open_nxt = open_sum - {{OPEN_W{1'b0}}, post_ok};
    if (open_nxt > OPEN_MAX) open_nxt = OPEN_MAX;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= '0;
      hold_q <= '0;
    end else begin
      open_q <= open_nxt[OPEN_W-1:0];
      if (post_ok)            hold_q <= hold_cyc_i;
      else if (hold_q != '0)  hold_q <= hold_q - 1'b1;
    end
  end

  assign read_open_o  = (open_q != '0);
  assign win_active_o = (open_q != '0) | (hold_q != '0);
endmodule

// File: rtl/odt_group_drive.sv
module odt_group_drive
  import dyn_read_odt_pkg::*;
#(
  parameter int unsigned NG = N_GRP
) (
  input  grp_cfg_t [NG-1:0] cfg_i,
  input  logic              common_i,
  input  logic              en_i,
  input  logic              win_active_i,
  output logic [NG-1:0]     odt_o
);
  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic lvl;
    assign lvl      = cfg_i[g].lvl | common_i;
    assign odt_o[g] = en_i & lvl & (~cfg_i[g].dyn | win_active_i);
  end
endmodule

// File: rtl/dyn_read_odt.sv
module dyn_read_odt
  import dyn_read_odt_pkg::*;
#(
  parameter int unsigned OPEN_W = 3,
  parameter int unsigned HOLD_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_en_i,
  input  logic              rd_start_i,
  input  logic              rd_post_i,
  input  logic              lead_sel_i,
  input  logic [HOLD_W-1:0] hold_cyc_i,
  input  logic              dq_dyn_i,
  input  logic              dqs_dyn_i,
  input  logic              dq_odt_cfg_i,
  input  logic              dqs_odt_cfg_i,
  input  logic              common_odt_i,
  output logic              dq_odt_o,
  output logic              dqs_odt_o
);
  logic [1:0]              open_cnt;
  logic                    read_open;
  logic                    win_active;
  grp_cfg_t [N_GRP-1:0]    grp_cfg;
  logic [N_GRP-1:0]        grp_odt;

  odt_lead_align u_lead (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_start_i (rd_start_i),
    .lead_sel_i (lead_sel_i),
    .open_cnt_o (open_cnt)
  );

  odt_window_track #(.OPEN_W(OPEN_W), .HOLD_W(HOLD_W)) u_win (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .open_cnt_i   (open_cnt),
    .rd_post_i    (rd_post_i),
    .hold_cyc_i   (hold_cyc_i),
    .read_open_o  (read_open),
    .win_active_o (win_active)
  );

  always_comb begin
    grp_cfg[GRP_DQ]  = '{dyn: dq_dyn_i,  lvl: dq_odt_cfg_i};
    grp_cfg[GRP_DQS] = '{dyn: dqs_dyn_i, lvl: dqs_odt_cfg_i};
  end

  odt_group_drive #(.NG(N_GRP)) u_drv (
    .cfg_i        (grp_cfg),
    .common_i     (common_odt_i),
    .en_i         (byte_en_i),
    .win_active_i (win_active),
    .odt_o        (grp_odt)
  );

  assign dq_odt_o  = grp_odt[GRP_DQ];
  assign dqs_odt_o = grp_odt[GRP_DQS];
endmodule

// File: rtl/dyn_read_odt_chk.sv
module dyn_read_odt_chk #(
  parameter int unsigned HOLD_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              byte_en_i,
  input logic              rd_start_i,
  input logic              rd_post_i,
  input logic              lead_sel_i,
  input logic [HOLD_W-1:0] hold_cyc_i,
  input logic              dq_dyn_i,
  input logic              dqs_dyn_i,
  input logic              dq_odt_cfg_i,
  input logic              common_odt_i,
  input logic              read_open,
  input logic              win_active,
  input logic              dq_odt_o,
  input logic              dqs_odt_o
);
  assert_lead_two_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_start_i && !lead_sel_i) |=> win_active);

  assert_lead_one_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_start_i && lead_sel_i) |=> ##1 win_active);

  assert_hold_open_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_post_i && read_open && hold_cyc_i != '0) |=> win_active);

  assert_dyn_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_dyn_i && !win_active) |-> !dq_odt_o);

  assert_common_or_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_en_i && common_odt_i && (!dq_dyn_i || win_active)) |-> dq_odt_o);

  assert_lane_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_en_i |-> (!dq_odt_o && !dqs_odt_o));

  assert_stray_post_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_post_i && !read_open && !win_active && !rd_start_i && !lead_sel_i) |=> !win_active);
endmodule

bind dyn_read_odt dyn_read_odt_chk #(.HOLD_W(HOLD_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .byte_en_i    (byte_en_i),
  .rd_start_i   (rd_start_i),
  .rd_post_i    (rd_post_i),
  .lead_sel_i   (lead_sel_i),
  .hold_cyc_i   (hold_cyc_i),
  .dq_dyn_i     (dq_dyn_i),
  .dqs_dyn_i    (dqs_dyn_i),
  .dq_odt_cfg_i (dq_odt_cfg_i),
  .common_odt_i (common_odt_i),
  .read_open    (read_open),
  .win_active   (win_active),
  .dq_odt_o     (dq_odt_o),
  .dqs_odt_o    (dqs_odt_o)
);

// File: tb/dyn_read_odt_tb.sv
module dyn_read_odt_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       byte_en_i = 1'b1;
  logic       rd_start_i = 1'b0;
  logic       rd_post_i = 1'b0;
  logic       lead_sel_i = 1'b0;
  logic [1:0] hold_cyc_i = 2'd0;
  logic       dq_dyn_i = 1'b1;
  logic       dqs_dyn_i = 1'b1;
  logic       dq_odt_cfg_i = 1'b1;
  logic       dqs_odt_cfg_i = 1'b1;
  logic       common_odt_i = 1'b0;
  logic       dq_odt_o;
  logic       dqs_odt_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk_i = ~clk_i;

  dyn_read_odt u_dut (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .byte_en_i     (byte_en_i),
    .rd_start_i    (rd_start_i),
    .rd_post_i     (rd_post_i),
    .lead_sel_i    (lead_sel_i),
    .hold_cyc_i    (hold_cyc_i),
    .dq_dyn_i      (dq_dyn_i),
    .dqs_dyn_i     (dqs_dyn_i),
    .dq_odt_cfg_i  (dq_odt_cfg_i),
    .dqs_odt_cfg_i (dqs_odt_cfg_i),
    .common_odt_i  (common_odt_i),
    .dq_odt_o      (dq_odt_o),
    .dqs_odt_o     (dqs_odt_o)
  );

  // {req[3:0], start, post, lead, hold[1:0], dyn dq/dqs, cfg dq/dqs, common, en, exp dq/dqs}
  localparam int NV = 56;
  localparam logic [16:0] VEC [NV] = '{
    {4'd2,  13'b1_0_0_00_11_11_0_1_00}, // R2 marker
    {4'd2,  13'b0_0_0_00_11_11_0_1_11}, // R2 opens at t+1
    {4'd2,  13'b0_0_0_00_11_11_0_1_11},
    {4'd2,  13'b0_0_0_00_11_11_0_1_11},
    {4'd4,  13'b0_1_0_00_11_11_0_1_11}, // R4 post, hold 0
    {4'd5,  13'b0_0_0_00_11_11_0_1_00}, // R5 closed outside window
    {4'd5,  13'b0_0_0_00_11_11_0_1_00},
    {4'd3,  13'b1_0_1_00_11_11_0_1_00}, // R3 marker, lead one
    {4'd3,  13'b0_0_1_00_11_11_0_1_00}, // R3 still closed at t+1
    {4'd3,  13'b0_0_1_00_11_11_0_1_11}, // R3 opens at t+2
    {4'd3,  13'b0_0_1_00_11_11_0_1_11},
    {4'd4,  13'b0_1_1_10_11_11_0_1_11}, // R4 post, hold 2
    {4'd4,  13'b0_0_1_10_11_11_0_1_11},
    {4'd4,  13'b0_0_1_10_11_11_0_1_11},
    {4'd4,  13'b0_0_1_10_11_11_0_1_00}, // R4 closes at p+3
    {4'd7,  13'b0_0_0_00_01_11_0_1_10}, // R7 dq static, dqs dynamic
    {4'd8,  13'b0_0_0_00_01_01_1_1_10}, // R8 common lifts dq
    {4'd6,  13'b0_0_0_00_01_01_0_1_00}, // R6 static level 0
    {4'd7,  13'b0_0_0_00_10_01_0_1_01}, // R7 dqs static, dq dynamic
    {4'd10, 13'b0_0_0_00_00_11_0_0_00}, // R10 lane off
    {4'd6,  13'b0_0_0_00_00_11_0_1_11}, // R6 static level 1
    {4'd9,  13'b1_0_0_01_11_11_0_1_00}, // R9 first read
    {4'd9,  13'b0_0_0_01_11_11_0_1_11},
    {4'd9,  13'b0_0_0_01_11_11_0_1_11},
    {4'd9,  13'b0_1_0_01_11_11_0_1_11},
    {4'd9,  13'b1_0_0_01_11_11_0_1_11}, // R9 hold cycle, second marker
    {4'd9,  13'b0_0_0_01_11_11_0_1_11}, // R9 no gap
    {4'd9,  13'b0_0_0_01_11_11_0_1_11},
    {4'd9,  13'b0_1_0_01_11_11_0_1_11},
    {4'd9,  13'b0_0_0_01_11_11_0_1_11},
    {4'd9,  13'b0_0_0_01_11_11_0_1_00},
    {4'd12, 13'b1_0_0_00_11_11_0_1_00}, // R12 overlap
    {4'd12, 13'b0_0_0_00_11_11_0_1_11},
    {4'd12, 13'b1_0_0_00_11_11_0_1_11},
    {4'd12, 13'b0_1_0_00_11_11_0_1_11},
    {4'd12, 13'b0_0_0_00_11_11_0_1_11}, // R12 one read still open
    {4'd12, 13'b0_1_0_00_11_11_0_1_11},
    {4'd12, 13'b0_0_0_00_11_11_0_1_00},
    {4'd11, 13'b0_1_0_00_11_11_0_1_00}, // R11 stray post
    {4'd11, 13'b0_0_0_00_11_11_0_1_00},
    {4'd11, 13'b1_0_0_00_11_11_0_1_00},
    {4'd11, 13'b0_0_0_00_11_11_0_1_11},
    {4'd11, 13'b0_1_0_00_11_11_0_1_11},
    {4'd11, 13'b0_0_0_00_11_11_0_1_00},
    {4'd8,  13'b1_0_0_00_11_00_1_1_00}, // R8 common in window
    {4'd8,  13'b0_0_0_00_11_00_1_1_11},
    {4'd8,  13'b0_1_0_00_11_00_1_1_11},
    {4'd8,  13'b0_0_0_00_11_00_1_1_00},
    {4'd5,  13'b1_0_0_00_11_01_0_1_00}, // R5 level 0 in window
    {4'd5,  13'b0_0_0_00_11_01_0_1_01},
    {4'd5,  13'b0_1_0_00_11_01_0_1_01},
    {4'd5,  13'b0_0_0_00_11_01_0_1_00},
    {4'd10, 13'b1_0_0_00_11_11_0_0_00}, // R10 window with lane off
    {4'd10, 13'b0_0_0_00_11_11_0_0_00},
    {4'd10, 13'b0_1_0_00_11_11_0_1_11},
    {4'd10, 13'b0_0_0_00_11_11_0_1_00}
  };

  task automatic check(input int req, input logic e_dq, input logic e_dqs);
    n_chk++;
    if (dq_odt_o !== e_dq || dqs_odt_o !== e_dqs) begin
      n_bad++;
      $display("FAIL R%0d: dq/dqs = %b%b, expected %b%b at %0t",
               req, dq_odt_o, dqs_odt_o, e_dq, e_dqs, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    #6;
    check(1, 1'b0, 1'b0); // R1 in reset
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #2 check(1, 1'b0, 1'b0); // R1 idle after release

    for (int i = 0; i < NV; i++) begin
      @(posedge clk_i);
      #2;
      rd_start_i    = VEC[i][12];
      rd_post_i     = VEC[i][11];
      lead_sel_i    = VEC[i][10];
      hold_cyc_i    = VEC[i][9:8];
      dq_dyn_i      = VEC[i][7];
      dqs_dyn_i     = VEC[i][6];
      dq_odt_cfg_i  = VEC[i][5];
      dqs_odt_cfg_i = VEC[i][4];
      common_odt_i  = VEC[i][3];
      byte_en_i     = VEC[i][2];
      #2 check(int'(VEC[i][16:13]), VEC[i][1], VEC[i][0]);
    end

    // R1: asynchronous reset while a window is open
    @(posedge clk_i);
    #2 rd_start_i = 1'b0; rd_post_i = 1'b0; lead_sel_i = 1'b0; hold_cyc_i = 2'd3;
    dq_dyn_i = 1'b1; dqs_dyn_i = 1'b1; dq_odt_cfg_i = 1'b1; dqs_odt_cfg_i = 1'b1;
    common_odt_i = 1'b0; byte_en_i = 1'b1;
    rd_start_i = 1'b1;
    @(posedge clk_i);
    #2 rd_start_i = 1'b0;
    #2 check(2, 1'b1, 1'b1);
    #1 rst_ni = 1'b0;
    #1 check(1, 1'b0, 1'b0);
    @(posedge clk_i);
    #2 rst_ni = 1'b1;
    #2 check(1, 1'b0, 1'b0);
    @(posedge clk_i);
    #2 rd_post_i = 1'b1; // R11 stray post after reset, hold 3
    @(posedge clk_i);
    #2 rd_post_i = 1'b0;
    #2 check(11, 1'b0, 1'b0);

    // R3: lead change right after a marker keeps the latched lead
    @(posedge clk_i);
    #2 lead_sel_i = 1'b1; rd_start_i = 1'b1; hold_cyc_i = 2'd0;
    @(posedge clk_i);
    #2 rd_start_i = 1'b0; lead_sel_i = 1'b0;
    #2 check(3, 1'b0, 1'b0);
    @(posedge clk_i);
    #4 check(3, 1'b1, 1'b1);

    finish_run();
  end
endmodule